// File: doc/BRIEF.md
# Buffered Crossbar Cell Scheduler

This block is the scheduling core of an N-by-N cell switch. Each input stores arriving cells in one virtual output queue (VOQ) per output. Each crosspoint of the crossbar holds a single cell. The block never computes a bipartite matching. Instead, in every scheduling phase two sets of round-robin arbiters work independently:

- Each input moves the head of one VOQ into its empty crosspoint.
- Each output then drains one occupied crosspoint in its column.

A time slot lasts three clock cycles: one arrival cycle followed by two scheduling cycles. This gives an internal speedup of two. Cells carry only a small tag in place of a payload.

Arrival uses a valid/ready pair. `in_ready` is a shared strobe that is high only in the arrival cycle of each slot. A cell counts as offered on input i when `in_valid[i]` and `in_ready` are both high. `in_valid` is ignored in every other cycle.

There is no further back-pressure on arrival. An offered cell whose VOQ is already full is dropped, and `in_drop[i]` pulses. The departure side has no ready signal: a downstream consumer must accept every `out_valid` beat.

Top module: `bxb_sched`

## Requirements
- R1: After reset `in_ready` is high in the first cycle and then exactly one cycle out of every three. No crosspoint is written or drained in a cycle where `in_ready` is high.
- R2: A cell is stored only when `in_valid[i]` and `in_ready` are both high. It goes into the VOQ of input i selected by `in_dest` (value j means output j). `in_valid` in any other cycle has no effect on later departures.
- R3: An offered cell whose VOQ already holds VOQ_DEPTH cells is discarded. `in_drop[i]` is then high for exactly the one cycle after the arrival cycle, and low at all other times.
- R4: In a scheduling cycle each input moves at most one cell, and only into a crosspoint that was empty at the start of that cycle.
- R5: In a scheduling cycle each output drains at most one occupied crosspoint. One cycle later it shows `out_valid[j]` high, with `out_src` set to the input index and `out_tag` set to the cell's tag.
- R6: An output with at least one occupied crosspoint in its column during a scheduling cycle always drains one (work conserving).
- R7: Each input's pointer starts at 0. An input grants the first eligible VOQ at or after its pointer, in cyclic order. After a grant the pointer moves to one past the granted output; with no grant it stays.
- R8: Each output's pointer starts at 0. An output grants the first occupied crosspoint at or after its pointer, in cyclic input order. After a grant the pointer moves to one past the granted input; with no grant it stays.
- R9: A cell moved into an empty crosspoint may be drained by its output in the same scheduling cycle. A lone cell arriving in slot cycle 0 therefore appears on its output port in slot cycle 2.
- R10: Cells from one input to one output depart in arrival order.
- R11: During and right after reset, all queues and crosspoints are empty and `out_valid` and `in_drop` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N | Per-input cell offer |
| in_dest | input | N*log2(N) | Per-input destination output, input i in slice i |
| in_tag | input | N*TAG_W | Per-input cell tag |
| in_ready | output | 1 | High in the arrival cycle of each slot |
| in_drop | output | N | One-cycle pulse: offered cell lost to a full VOQ |
| out_valid | output | N | Per-output departure strobe |
| out_src | output | N*log2(N) | Input the departing cell came from |
| out_tag | output | N*TAG_W | Tag of the departing cell |

## Verification
The hardest state to reach from the ports is a backed-up VOQ. Each input receives one cell per slot but can forward two, so queues only grow when outputs are oversubscribed. Directed bursts therefore send every input's cells to the same output for many slots. This keeps its column full, exercises the output pointer's rotation under constant contention, and drives VOQs into overflow.

Constrained random traffic with a skewed destination mix follows. It also toggles `in_valid` outside arrival cycles. Every departure, drop pulse and ready strobe is compared with a slot-level model written from the requirements.

// File: rtl/bxb_pkg.sv
package bxb_pkg;
  typedef enum logic [1:0] {
    PH_ARRIVE  = 2'd0,
    PH_SCHED_A = 2'd1,
    PH_SCHED_B = 2'd2
  } phase_e;
endpackage

// File: rtl/bxb_rr_arb.sv
module bxb_rr_arb #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          advance,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx
);
  logic [IW-1:0] ptr;
  logic          found;

  always_comb begin
    logic [IW-1:0] idx;
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    for (int k = 0; k < N; k++) begin
      idx = IW'((32'(ptr) + 32'(k)) % N);
      if (!found && req[idx]) begin
        found        = 1'b1;
        gnt[idx]     = 1'b1;
        gnt_idx      = idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (advance && found) begin
      ptr <= (gnt_idx == IW'(N-1)) ? '0 : gnt_idx + 1'b1;
    end
  end
endmodule

// File: rtl/bxb_voq_bank.sv
module bxb_voq_bank #(
  parameter int N     = 4,
  parameter int DEPTH = 8,
  parameter int TAG_W = 8,
  localparam int IW = $clog2(N),
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [IW-1:0]    push_dest,
  input  logic [TAG_W-1:0] push_tag,
  input  logic [N-1:0]     pop,
  output logic [N-1:0]     not_empty,
  output logic [N-1:0]     is_full,
  output logic [N*TAG_W-1:0] head_tag
);
  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar j = 0; j < N; j++) begin : g_q
    logic [TAG_W-1:0] mem [DEPTH];
    logic [AW-1:0]    rp, wp;
    logic [AW:0]      cnt;
    logic             wr;

    assign wr = push && (push_dest == IW'(j)) && !is_full[j];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rp  <= '0;
        wp  <= '0;
        cnt <= '0;
      end else begin
        if (wr)     wp <= bump(wp);
        if (pop[j]) rp <= bump(rp);
        cnt <= cnt + {{AW{1'b0}}, wr} - {{AW{1'b0}}, pop[j]};
      end
    end

    always_ff @(posedge clk) begin
      if (wr) mem[wp] <= push_tag;
    end

    assign not_empty[j]              = (cnt != '0);
    assign is_full[j]                = (cnt == (AW+1)'(DEPTH));
    assign head_tag[j*TAG_W +: TAG_W] = mem[rp];
  end
endmodule

// File: rtl/bxb_sched.sv
module bxb_sched
  import bxb_pkg::*;
#(
  parameter int N         = 4,
  parameter int VOQ_DEPTH = 8,
  parameter int TAG_W     = 8,
  localparam int IW = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       in_valid,
  input  logic [N*IW-1:0]    in_dest,
  input  logic [N*TAG_W-1:0] in_tag,
  output logic               in_ready,
  output logic [N-1:0]       in_drop,
  output logic [N-1:0]       out_valid,
  output logic [N*IW-1:0]    out_src,
  output logic [N*TAG_W-1:0] out_tag
);
  phase_e phase;
  logic   sched;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_ARRIVE;
    end else begin
      case (phase)
        PH_ARRIVE:  phase <= PH_SCHED_A;
        PH_SCHED_A: phase <= PH_SCHED_B;
        default:    phase <= PH_ARRIVE;
      endcase
    end
  end

  assign in_ready = (phase == PH_ARRIVE);
  assign sched    = !in_ready;

  // row-indexed state: [input][output]
  logic [N-1:0]       voq_ne   [N];
  logic [N-1:0]       voq_full [N];
  logic [N*TAG_W-1:0] voq_head [N];
  logic [N-1:0]       in_gnt   [N];
  logic [N-1:0]       xp_full  [N];
  logic [TAG_W-1:0]   xp_tag   [N][N];
  // column-indexed: [output][input]
  logic [N-1:0]       out_gnt  [N];
  logic [IW-1:0]      out_idx  [N];

  // flat views for the checker, bit i*N+j = input i, output j
  logic [N*N-1:0] in_gnt_flat, xp_flat, out_gnt_flat;

  for (genvar i = 0; i < N; i++) begin : g_in
    logic [IW-1:0] dest;
    logic [N-1:0]  req;
    logic [IW-1:0] unused_idx;

    assign dest = in_dest[i*IW +: IW];
    assign req  = sched ? (voq_ne[i] & ~xp_full[i]) : '0;

    bxb_voq_bank #(.N(N), .DEPTH(VOQ_DEPTH), .TAG_W(TAG_W)) u_voq (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (in_valid[i] & in_ready),
      .push_dest (dest),
      .push_tag  (in_tag[i*TAG_W +: TAG_W]),
      .pop       (in_gnt[i]),
      .not_empty (voq_ne[i]),
      .is_full   (voq_full[i]),
      .head_tag  (voq_head[i])
    );

    bxb_rr_arb #(.N(N)) u_iarb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .advance (sched),
      .gnt     (in_gnt[i]),
      .gnt_idx (unused_idx)
    );

    always_ff @(posedge clk) begin
      if (!rst_n) in_drop[i] <= 1'b0;
      else        in_drop[i] <= in_valid[i] & in_ready & voq_full[i][dest];
    end

    for (genvar j = 0; j < N; j++) begin : g_xp
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          xp_full[i][j] <= 1'b0;
        end else begin
          xp_full[i][j] <= (xp_full[i][j] | in_gnt[i][j]) & ~out_gnt[j][i];
        end
      end
      always_ff @(posedge clk) begin
        if (in_gnt[i][j]) xp_tag[i][j] <= voq_head[i][j*TAG_W +: TAG_W];
      end
      assign in_gnt_flat[i*N+j]  = in_gnt[i][j];
      assign xp_flat[i*N+j]      = xp_full[i][j];
      assign out_gnt_flat[i*N+j] = out_gnt[j][i];
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_out
    logic [N-1:0]     col_req;
    logic [TAG_W-1:0] sel_tag;

    for (genvar i = 0; i < N; i++) begin : g_col
      assign col_req[i] = sched & (xp_full[i][j] | in_gnt[i][j]);
    end

    bxb_rr_arb #(.N(N)) u_oarb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (col_req),
      .advance (sched),
      .gnt     (out_gnt[j]),
      .gnt_idx (out_idx[j])
    );

    // a cell written this phase bypasses the crosspoint register
    assign sel_tag = in_gnt[out_idx[j]][j] ? voq_head[out_idx[j]][j*TAG_W +: TAG_W]
                                           : xp_tag[out_idx[j]][j];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_valid[j]               <= 1'b0;
        out_src[j*IW +: IW]        <= '0;
        out_tag[j*TAG_W +: TAG_W]  <= '0;
      end else begin
        out_valid[j]               <= |out_gnt[j];
        out_src[j*IW +: IW]        <= out_idx[j];
        out_tag[j*TAG_W +: TAG_W]  <= sel_tag;
      end
    end
  end
endmodule

// File: rtl/bxb_chk.sv
module bxb_chk #(
  parameter int N = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_ready,
  input logic [N-1:0]   in_drop,
  input logic [N*N-1:0] in_gnt,
  input logic [N*N-1:0] xp_full,
  input logic [N*N-1:0] out_gnt
);
  AST_READY_CADENCE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready); // R1
  AST_NO_GRANT_ON_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (in_gnt == '0 && out_gnt == '0)); // R1

  for (genvar i = 0; i < N; i++) begin : g_row
    AST_IN_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(in_gnt[i*N +: N])); // R4
    AST_DROP_AFTER_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
      in_drop[i] |-> $past(in_ready)); // R3
    for (genvar j = 0; j < N; j++) begin : g_cell
      AST_IN_EMPTY_XP: assert property (@(posedge clk) disable iff (!rst_n)
        in_gnt[i*N+j] |-> !xp_full[i*N+j]); // R4
      AST_OUT_FROM_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_n)
        out_gnt[i*N+j] |-> (xp_full[i*N+j] | in_gnt[i*N+j])); // R5
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_colchk
    logic [N-1:0] occ, gnt;
    for (genvar i = 0; i < N; i++) begin : g_c
      assign occ[i] = xp_full[i*N+j] | in_gnt[i*N+j];
      assign gnt[i] = out_gnt[i*N+j];
    end
    AST_OUT_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt)); // R5
    AST_WORK_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_ready && (|occ)) |-> (|gnt)); // R6
  end
endmodule

bind bxb_sched bxb_chk #(.N(N)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_ready(in_ready),
  .in_drop (in_drop),
  .in_gnt  (in_gnt_flat),
  .xp_full (xp_flat),
  .out_gnt (out_gnt_flat)
);

// File: tb/tb_bxb_sched.sv
`timescale 1ns/1ps
module tb_bxb_sched;
  localparam int N = 4, IW = 2, TW = 8, DEPTH = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    in_valid;
  logic [N*IW-1:0] in_dest;
  logic [N*TW-1:0] in_tag;
  logic            in_ready;
  logic [N-1:0]    in_drop;
  logic [N-1:0]    out_valid;
  logic [N*IW-1:0] out_src;
  logic [N*TW-1:0] out_tag;

  always #2 clk = ~clk;

  bxb_sched #(.N(N), .VOQ_DEPTH(DEPTH), .TAG_W(TW)) dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  logic [7:0] mq [N][N][$];
  bit         mxp [N][N];
  logic [7:0] mxt [N][N];
  int         iptr [N], optr [N];
  int         mph;
  bit         ev [N];
  int         es [N];
  logic [7:0] et [N];
  bit         ed [N];
  // stimulus for the current cycle
  bit         av [N];
  int         ad [N];
  logic [7:0] at [N];
  logic [7:0] tagc = 8'd1;
  bit         saw_drop = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_step();
    if (mph == 0) begin
      for (int i = 0; i < N; i++) begin
        ed[i] = 0;
        if (av[i]) begin
          if (mq[i][ad[i]].size() == DEPTH) ed[i] = 1;
          else mq[i][ad[i]].push_back(at[i]);
        end
      end
      for (int j = 0; j < N; j++) ev[j] = 0;
    end else begin
      for (int i = 0; i < N; i++) begin
        bit f = 0;
        ed[i] = 0;
        for (int k = 0; k < N; k++) begin
          int j = (iptr[i] + k) % N;
          if (!f && mq[i][j].size() > 0 && !mxp[i][j]) begin
            f = 1;
            mxp[i][j] = 1;
            mxt[i][j] = mq[i][j].pop_front();
            iptr[i] = (j + 1) % N;
          end
        end
      end
      for (int j = 0; j < N; j++) begin
        bit f = 0;
        ev[j] = 0;
        for (int k = 0; k < N; k++) begin
          int i = (optr[j] + k) % N;
          if (!f && mxp[i][j]) begin
            f = 1;
            ev[j] = 1; es[j] = i; et[j] = mxt[i][j];
            mxp[i][j] = 0;
            optr[j] = (i + 1) % N;
          end
        end
      end
    end
    mph = (mph + 1) % 3;
  endfunction

  // called at a negedge: compare, drive, advance model, move to next negedge
  task automatic tick();
    chk(in_ready === (mph == 0), "R1 ready", int'(in_ready), int'(mph == 0));
    for (int j = 0; j < N; j++) begin
      chk(out_valid[j] === ev[j], "R5 R2 valid", int'(out_valid[j]), int'(ev[j]));
      if (ev[j] && out_valid[j]) begin
        chk(int'(out_src[j*IW +: IW]) == es[j], "R8 src", int'(out_src[j*IW +: IW]), es[j]);
        chk(out_tag[j*TW +: TW] == et[j], "R7 R10 tag", int'(out_tag[j*TW +: TW]), int'(et[j]));
      end
      chk(in_drop[j] === ed[j], "R3 drop", int'(in_drop[j]), int'(ed[j]));
      if (in_drop[j]) saw_drop = 1;
    end
    for (int i = 0; i < N; i++) begin
      in_valid[i]          = av[i];
      in_dest[i*IW +: IW]  = IW'(ad[i]);
      in_tag[i*TW +: TW]   = at[i];
    end
    model_step();
    @(negedge clk);
  endtask

  task automatic clear_stim();
    for (int i = 0; i < N; i++) begin av[i] = 0; ad[i] = 0; at[i] = 8'd0; end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    int seed_init;
    seed_init = $urandom(32'd2718);
    rst_n = 1'b0; in_valid = '0; in_dest = '0; in_tag = '0;
    clear_stim();
    for (int i = 0; i < N; i++) begin
      iptr[i] = 0; optr[i] = 0; ev[i] = 0; es[i] = 0; et[i] = 0; ed[i] = 0;
      for (int j = 0; j < N; j++) begin mxp[i][j] = 0; mxt[i][j] = 0; end
    end
    mph = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(out_valid === '0, "R11 out_valid", int'(out_valid), 0);
    chk(in_drop === '0, "R11 in_drop", int'(in_drop), 0);
    in_valid = '1;  // R11: offers during reset must not enter queues
    @(negedge clk);
    in_valid = '0;
    rst_n = 1'b1;

    // R9 lone cell crosses in the same phase
    av[0] = 1; ad[0] = 2; at[0] = 8'hA5;
    tick();
    clear_stim();
    tick();
    chk(out_valid[2] === 1'b1 && out_src[5:4] == 2'd0 && out_tag[23:16] == 8'hA5,
        "R9 pass-through", int'(out_tag[23:16]), 8'hA5);
    tick();

    // R3 R6 R8: all inputs oversubscribe output 0
    for (int s = 0; s < 30 * 3; s++) begin
      for (int i = 0; i < N; i++) begin av[i] = 1; ad[i] = 0; at[i] = tagc; tagc++; end
      tick();
    end
    clear_stim();
    chk(saw_drop, "R3 overflow seen", int'(saw_drop), 1);
    for (int s = 0; s < 60 * 3; s++) tick();

    // random traffic with skewed destinations, junk valid outside arrival
    for (int s = 0; s < 2400; s++) begin
      for (int i = 0; i < N; i++) begin
        av[i] = ($urandom_range(0, 99) < 65);
        ad[i] = ($urandom_range(0, 3) == 0) ? 1 : int'($urandom_range(0, 3));
        at[i] = tagc; tagc++;
      end
      tick();
    end
    clear_stim();
    for (int s = 0; s < 80 * 3; s++) tick();
    chk(out_valid === '0, "R6 drained idle", int'(out_valid), 0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired R1 actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule